// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one data character per request into an asynchronous serial frame on a single transmit line. A character is offered on a valid/ready handshake. The block then drives the line low for one start bit. The data bits follow, then an optional parity bit, then one or two high stop bits. Each bit is held for a fixed number of enable pulses from an external baud tick, so the bit rate is set entirely outside the block.

The frame shape comes from a five-bit format register. The register selects the bit order, the character length (seven or eight bits), the parity treatment (none, a forced zero, odd or even) and the stop length. The register takes a write only while the block is powered down, or while both the transmit and the receive direction are switched off. Any other write is dropped. The reset value of the register is a framing that suits LIN-style traffic: least significant bit first, eight data bits, no parity and one stop bit.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset the transmit line is high. While idle the line stays high, and `in_ready` is high whenever `pwr_on` and `tx_enable` are both 1.
- R2: A frame opens with exactly one low start bit. The data bits follow it, then the parity bit (if enabled), then the stop bits.
- R3: Format bit 4 selects the order: 0 sends the most significant data bit first, and 1 sends the least significant bit first.
- R4: Format bit 1 selects the length: 0 sends 7 data bits (data bit 7 is ignored), and 1 sends 8 data bits.
- R5: Format bits [3:2] select the parity. 00 sends no parity bit and 01 sends a parity bit that is always 0. 10 sends odd parity and 11 sends even parity, each taken over the configured data bits only.
- R6: Format bit 0 selects one high stop bit (0) or two high stop bits (1). A frame always ends on a high line.
- R7: Every bit of the frame lasts exactly 16 `baud_tick` pulses.
- R8: A format write (`cfg_we`) takes effect only when `pwr_on` is 0, or when `tx_enable` and `rx_enable` are both 0. Otherwise the register keeps its old value.
- R9: A character is taken only when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` stays low from the start bit until the last stop bit has ended, and it is low while `pwr_on` or `tx_enable` is 0.
- R10: Out of reset the format is LSB first, 8 data bits, no parity and 1 stop bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle enable, 16 per bit time |
| pwr_on | input | 1 | Block powered; while 0 the format register is writable |
| tx_enable | input | 1 | Transmit direction enabled |
| rx_enable | input | 1 | Receive direction enabled (used only for the write lock) |
| cfg_we | input | 1 | Format register write strobe |
| cfg_wdata | input | 5 | [4] order, [3:2] parity, [1] length, [0] stop length |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Character can be taken |
| in_data | input | 8 | Character to send |
| txd | output | 1 | Serial output, idles high |

## Verification
The line falls low in the clock cycle after the accepting edge. From then on, each bit boundary comes on the clock edge that takes the 16th baud tick of that bit, so a frame of n bits ends after 16·n ticks. The monitor counts the ticks that the clock edges take after the start. It compares the line at the 8th tick of each bit and at the last clock before the 16th tick. The first sample after the final tick must show a high line and `in_ready` high again. Format writes that the lock rule allows update the bench's own model at once, and the next frame that is taken uses the model's value.

// File: rtl/uart_tx_pkg.sv
// Shared types for the UART frame transmitter.
// Assumes: the format word is packed as {order, parity[1:0], length, stop}.
package uart_tx_pkg;

    typedef struct packed {
        logic       lsb_first;
        logic [1:0] par_mode;
        logic       len_full;
        logic       stop_two;
    } txcfg_t;

    localparam int CFG_W = $bits(txcfg_t);

    localparam logic [1:0] PAR_NONE = 2'b00;
    localparam logic [1:0] PAR_ZERO = 2'b01;
    localparam logic [1:0] PAR_ODD  = 2'b10;
    localparam logic [1:0] PAR_EVEN = 2'b11;

    localparam txcfg_t CFG_RESET = '{lsb_first: 1'b1, par_mode: PAR_NONE,
                                     len_full: 1'b1, stop_two: 1'b0};

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } txst_t;

endpackage

// File: rtl/uart_tx_cfg.sv
// Format register with write lock.
// Holds the frame format. A write is taken only while the block is powered
// down, or while both directions are disabled.
// Assumes: the lock inputs are synchronous to clk.
module uart_tx_cfg
    import uart_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_on,
    input  logic             tx_en,
    input  logic             rx_en,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output txcfg_t           cfg
);

    logic unlocked;

    // Purpose: decide whether the register may change this cycle.
    always_comb begin
        unlocked = !pwr_on || (!tx_en && !rx_en);
    end

    // Purpose: hold the format; load it on a permitted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= CFG_RESET;
        end else if (we && unlocked) begin
            cfg <= txcfg_t'(wdata);
        end
    end

    // R8: with the lock closed, the register must not move.
    a_r8_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_on && (tx_en || rx_en)) |=> $stable(cfg));

endmodule

// File: rtl/uart_tx_bitclk.sv
// Bit timer.
// Counts baud ticks while a frame is active and flags the tick that ends
// the current bit.
// Assumes: baud_tick is a one-cycle enable; the count restarts when run is low.
module uart_tx_bitclk #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic bit_end
);

    localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    logic [CW-1:0] cnt;

    // Purpose: flag the last tick of a bit period.
    always_comb begin
        bit_end = run && tick && (cnt == LAST);
    end

    // Purpose: step the tick count within the current bit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/uart_tx_frame.sv
// Frame sequencer and shifter.
// Latches a character and its format on load. It then walks through the
// start, data, parity and stop phases, advancing one phase on each bit_end.
// Assumes: load only arrives while idle; bit_end only while busy.
module uart_tx_frame
    import uart_tx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  txcfg_t        cfg,
    input  logic          bit_end,
    input  logic          tick,
    output logic          busy,
    output logic          txd
);

    localparam int IW = $clog2(DW + 1);

    txst_t         st;
    logic [DW-1:0] sh;
    logic [IW-1:0] left;
    logic          par_q;
    logic          par_en_q;
    logic          stop_more;

    logic [DW-1:0] rev_full;
    logic [DW-1:0] rev_short;
    logic [DW-1:0] mask;
    logic [DW-1:0] ordered;
    logic [IW-1:0] nbits;
    logic          xsum;
    logic          par_bit;

    // Reverse the character for MSB-first sending, at both lengths.
    for (genvar i = 0; i < DW; i++) begin : g_ord
        assign rev_full[i] = load_data[DW-1-i];
        if (i < DW - 1) begin : g_s
            assign rev_short[i] = load_data[DW-2-i];
        end else begin : g_z
            assign rev_short[i] = 1'b0;
        end
    end

    // Purpose: prepare shift contents, bit count and parity for a load.
    always_comb begin
        mask    = cfg.len_full ? {DW{1'b1}} : {1'b0, {(DW-1){1'b1}}};
        nbits   = cfg.len_full ? IW'(DW) : IW'(DW - 1);
        ordered = cfg.lsb_first ? (load_data & mask)
                                : (cfg.len_full ? rev_full : rev_short);
        xsum    = ^(load_data & mask);
        case (cfg.par_mode)
            PAR_ODD:  par_bit = ~xsum;
            PAR_EVEN: par_bit = xsum;
            default:  par_bit = 1'b0;
        endcase
    end

    // Purpose: sequence the frame phases and shift out the data bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            sh        <= '0;
            left      <= '0;
            par_q     <= 1'b0;
            par_en_q  <= 1'b0;
            stop_more <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (load) begin
                    st        <= ST_START;
                    sh        <= ordered;
                    left      <= nbits;
                    par_q     <= par_bit;
                    par_en_q  <= (cfg.par_mode != PAR_NONE);
                    stop_more <= cfg.stop_two;
                end
                ST_START: if (bit_end) st <= ST_DATA;
                ST_DATA: if (bit_end) begin
                    sh   <= sh >> 1;
                    left <= left - 1'b1;
                    if (left == IW'(1)) st <= par_en_q ? ST_PAR : ST_STOP;
                end
                ST_PAR: if (bit_end) st <= ST_STOP;
                ST_STOP: if (bit_end) begin
                    if (stop_more) stop_more <= 1'b0;
                    else           st        <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Purpose: drive the line level for the current phase.
    always_comb begin
        case (st)
            ST_START: txd = 1'b0;
            ST_DATA:  txd = sh[0];
            ST_PAR:   txd = par_q;
            default:  txd = 1'b1;
        endcase
        busy = (st != ST_IDLE);
    end

    // R7: without a baud tick, the phase and the shifter hold.
    a_r7_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && !tick) |=> ($stable(st) && $stable(sh)));

    // R5: with parity off, the last data bit leads straight to the stop bits.
    a_r5_skip_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA && bit_end && left == IW'(1) && !par_en_q) |=> (st == ST_STOP));

endmodule

// File: rtl/uart_frame_tx.sv
// UART frame transmitter top.
// Ties the format register, bit timer and frame sequencer together, and
// decides when a character can be taken.
// Assumes: baud_tick comes from an external rate generator, 16 per bit.
module uart_frame_tx
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              pwr_on,
    input  logic              tx_enable,
    input  logic              rx_enable,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              txd
);

    txcfg_t cfg;
    logic   busy;
    logic   bit_end;
    logic   accept;

    uart_tx_cfg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .pwr_on(pwr_on),
        .tx_en (tx_enable),
        .rx_en (rx_enable),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    uart_tx_bitclk #(.OVS(OVS)) u_bitclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (busy),
        .tick   (baud_tick),
        .bit_end(bit_end)
    );

    uart_tx_frame #(.DW(DATA_W)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_data(in_data),
        .cfg      (cfg),
        .bit_end  (bit_end),
        .tick     (baud_tick),
        .busy     (busy),
        .txd      (txd)
    );

    // Purpose: offer ready only when idle, powered and transmit-enabled.
    always_comb begin
        in_ready = !busy && pwr_on && tx_enable;
        accept   = in_valid && in_ready;
    end

    // R9: a taken character puts the start bit on the line next cycle.
    a_r9_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !txd);

    // R1: whenever ready is offered, the line is idle high.
    a_r1_ready_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> txd);

    // R6: a frame finishes on a high stop bit and leaves the line high.
    a_r6_ends_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(txd) && txd));

endmodule

// File: tb/uart_frame_tx_test.sv
`timescale 1ns/1ps
module uart_frame_tx_test;

    typedef struct {
        logic [11:0] bits;
        int          n;
        int          nstop;
        int          par_idx;
        string       tag;
    } frame_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       pwr_on = 1'b1;
    logic       tx_enable = 1'b1;
    logic       rx_enable = 1'b1;
    logic       cfg_we = 1'b0;
    logic [4:0] cfg_wdata = '0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = '0;
    logic       txd;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    frame_t     expq[$];
    frame_t     cur;
    logic [4:0] model_cfg = 5'b1_00_1_0;
    bit         in_frame = 0;
    bit         end_pending = 0;
    int         tcnt = 0;

    uart_frame_tx uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .baud_tick(baud_tick),
        .pwr_on   (pwr_on),
        .tx_enable(tx_enable),
        .rx_enable(rx_enable),
        .cfg_we   (cfg_we),
        .cfg_wdata(cfg_wdata),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_data  (in_data),
        .txd      (txd)
    );

    always #4 clk = ~clk;

    // Baud tick: one pulse every third clock.
    initial begin
        int div = 0;
        forever begin
            @(posedge clk);
            #1;
            div = (div == 2) ? 0 : div + 1;
            baud_tick = (div == 0);
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Expected frame from the requirements: start, data, parity, stops.
    function automatic frame_t build(input logic [7:0] d, input logic [4:0] c, input string tag);
        frame_t f;
        int nb = c[1] ? 8 : 7;
        logic x = ^(d & (c[1] ? 8'hFF : 8'h7F));
        f.bits = '0; f.n = 0; f.tag = tag; f.par_idx = -1;
        f.bits[f.n] = 1'b0; f.n++;
        for (int k = 0; k < nb; k++) begin
            f.bits[f.n] = c[4] ? d[k] : d[nb-1-k];
            f.n++;
        end
        if (c[3:2] != 2'b00) begin
            f.par_idx = f.n;
            f.bits[f.n] = (c[3:2] == 2'b01) ? 1'b0 : (c[3:2] == 2'b10) ? ~x : x;
            f.n++;
        end
        f.nstop = c[0] ? 2 : 1;
        for (int k = 0; k < f.nstop; k++) begin
            f.bits[f.n] = 1'b1; f.n++;
        end
        return f;
    endfunction

    task automatic write_cfg(input logic [4:0] c);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_wdata = c;
        if (!pwr_on || (!tx_enable && !rx_enable)) model_cfg = c;   // R8 rule
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic send(input logic [7:0] d, input string tag);
        @(posedge clk); #1;
        in_valid = 1'b1; in_data = d;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        in_valid = 1'b0;
        expq.push_back(build(d, model_cfg, tag));
    endtask

    task automatic drain();
        do @(negedge clk); while (expq.size() != 0 || in_frame);
        repeat (4) @(negedge clk);
    endtask

    // Monitor: follow the frame by counting taken baud ticks.
    always @(negedge clk) begin
        if (!rst_n) begin
            in_frame = 0;
            end_pending = 0;
        end else begin
            if (!in_frame && txd === 1'b0) begin
                if (expq.size() == 0) begin
                    chk(0, "R2", "unexpected start bit", 0, 1);
                end else begin
                    cur = expq.pop_front();
                    in_frame = 1; tcnt = 0; end_pending = 0;
                end
            end
            if (in_frame) begin
                if (end_pending) begin
                    // R9: ready back and line high right after the last stop tick.
                    chk(txd === 1'b1, "R6", {cur.tag, " line after frame"}, txd, 1);
                    chk(in_ready === (pwr_on && tx_enable), "R9",
                        {cur.tag, " ready after frame"}, in_ready, 1);
                    in_frame = 0; end_pending = 0;
                end else if (baud_tick === 1'b1) begin
                    int k = tcnt / 16;
                    int ph = tcnt % 16;
                    string role;
                    if (k == 0) role = "R2";
                    else if (k >= cur.n - cur.nstop) role = "R6";
                    else if (k == cur.par_idx) role = "R5";
                    else role = "R3";
                    if (ph == 8) begin
                        chk(txd === cur.bits[k], role,
                            $sformatf("%s bit %0d mid", cur.tag, k), txd, cur.bits[k]);
                        chk(in_ready === 1'b0, "R9", {cur.tag, " ready in frame"}, in_ready, 0);
                    end
                    if (ph == 15) begin
                        // R7: bit still held before its 16th tick.
                        chk(txd === cur.bits[k], "R7",
                            $sformatf("%s bit %0d late", cur.tag, k), txd, cur.bits[k]);
                    end
                    tcnt++;
                    if (tcnt == 16 * cur.n) end_pending = 1;
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            vectors++; miscompares++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(txd === 1'b1, "R1", "line after reset", txd, 1);
        chk(in_ready === 1'b1, "R1", "ready after reset", in_ready, 1);

        // R10: reset format, LSB first 8N1.
        send(8'hA5, "R10");
        send(8'h3C, "R10");
        drain();

        // R8: locked writes are ignored, seen on the next frame.
        write_cfg(5'b0_11_0_1);
        send(8'h96, "R8");
        drain();
        tx_enable = 1'b0;
        write_cfg(5'b0_10_1_1);
        @(negedge clk);
        chk(in_ready === 1'b0, "R9", "ready with tx disabled", in_ready, 0);
        tx_enable = 1'b1;
        send(8'h0F, "R8");
        drain();

        // R4, R5: unlocked by both directions off: MSB, odd, 7 bits, 2 stops.
        tx_enable = 1'b0; rx_enable = 1'b0;
        write_cfg(5'b0_10_0_1);
        tx_enable = 1'b1; rx_enable = 1'b1;
        send(8'hDB, "R4");
        send(8'h5A, "R5");
        drain();

        // R3: unlocked by power off: MSB, even, 8 bits, 1 stop.
        pwr_on = 1'b0;
        write_cfg(5'b0_11_1_0);
        @(negedge clk);
        chk(in_ready === 1'b0, "R9", "ready with power off", in_ready, 0);
        pwr_on = 1'b1;
        send(8'hC3, "R3");
        send(8'h01, "R5");
        drain();

        // R5, R4: forced zero parity, LSB, 7 bits, 2 stops.
        pwr_on = 1'b0;
        write_cfg(5'b1_01_0_1);
        pwr_on = 1'b1;
        send(8'hFF, "R5");
        send(8'h80, "R4");
        drain();

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule